// File: doc/BRIEF.md
# Out-of-Frame Monitor and Resync Control

This block watches the framing bits of a receive framer that is already locked. The framer gives one error flag for each framing bit, qualified by a valid strobe. The block keeps a short history of those results and declares out-of-frame when two errors fall inside a window whose length is selected by a two-bit control.

It also decides when the frame synchronizer must start a new search. It issues a single-cycle start pulse on any of three triggers: an out-of-frame declaration, the rising edge of a receive loss-of-signal input, or the rising edge of a manual resync control. The automatic triggers can be turned off. Loss of signal can also be excluded, so that only out-of-frame starts a search on its own. The synchronizer reports back when it has regained alignment, and that report re-arms the block.

Top module: `oof_resync_ctrl`

## Requirements
- R1: After reset, `oof` and `resync_start` are 0 and the error history is empty.
- R2: With `oof_rule` = 00, `oof` is set when at least 2 of the 4 most recent valid framing bits were in error. Errors spaced 5 bits apart do not set it.
- R3: With `oof_rule` = 01, the window is the 5 most recent valid framing bits. Errors spaced 6 bits apart do not set it.
- R4: With `oof_rule` = 10 or 11, the window is the 6 most recent valid framing bits. Errors spaced 7 bits apart do not set it.
- R5: The history advances only in cycles where `fb_valid` = 1. `fb_err` has no effect in other cycles.
- R6: `sync_regained` = 1 clears `oof` and empties the error history on the next edge, so a single later error does not set `oof`.
- R7: With `auto_off` = 0, `resync_start` pulses for exactly one cycle. The pulse comes in the same cycle that `oof` first reads 1.
- R8: With `auto_off` = 1, neither out-of-frame nor loss of signal produces a pulse, although `oof` is still declared.
- R9: With `auto_off` = 0 and `oof_only` = 0, a 0-to-1 edge on `rlos` produces one pulse. With `oof_only` = 1, it produces none.
- R10: A 0-to-1 edge on `manual_rs` produces one pulse, whatever the value of `auto_off`. Holding `manual_rs` high gives no further pulses; it must fall and rise again.
- R11: After a pulse, no further pulse is issued from any trigger until `sync_regained` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_valid | input | 1 | Framing-bit result strobe |
| fb_err | input | 1 | Framing bit in error, qualified by fb_valid |
| rlos | input | 1 | Receive loss of signal |
| sync_regained | input | 1 | Synchronizer has regained alignment |
| oof_rule | input | 2 | Window select: 00 = 4 bits, 01 = 5 bits, 1x = 6 bits |
| auto_off | input | 1 | 1 disables automatic resync |
| oof_only | input | 1 | 1 limits the automatic trigger to out-of-frame |
| manual_rs | input | 1 | Manual resync, acts on its rising edge |
| oof | output | 1 | Out-of-frame status |
| resync_start | output | 1 | One-cycle request to start a frame search |

## Verification
Each result comes one register stage after its stimulus. `oof` and `resync_start` both change at the same edge that samples the deciding framing bit, the `rlos` edge or the `manual_rs` edge. The clear caused by `sync_regained` also appears after one edge. The bench drives inputs on the falling clock edge for exactly one cycle, then reads `oof` at the next falling edge, which lies just after the edge that acted. A falling-edge counter adds up the `resync_start` pulses, so each scenario compares its pulse total against the expected number rather than relying on the moment it happens to look.

// File: rtl/oof_resync_ctrl.sv
module oof_resync_ctrl #(
  parameter int WIN = 6,
  parameter int ERR_LIMIT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_valid,
  input  logic       fb_err,
  input  logic       rlos,
  input  logic       sync_regained,
  input  logic [1:0] oof_rule,
  input  logic       auto_off,
  input  logic       oof_only,
  input  logic       manual_rs,
  output logic       oof,
  output logic       resync_start
);

  localparam int CW = $clog2(WIN + 1);

  logic [WIN-1:0] hist, hist_nx, mask;
  logic [CW-1:0]  err_cnt;
  logic           rlos_q, man_q, busy;
  logic           oof_set, rlos_rise, man_rise, auto_hit, fire;

  always_comb begin
    case (oof_rule)
      2'b00:   mask = WIN'((1 << 4) - 1);
      2'b01:   mask = WIN'((1 << 5) - 1);
      default: mask = WIN'((1 << 6) - 1);
    endcase
  end

  assign hist_nx = {hist[WIN-2:0], fb_err};

  always_comb begin
    err_cnt = '0;
    for (int i = 0; i < WIN; i++)
      err_cnt = err_cnt + CW'(hist_nx[i] & mask[i]);
  end

  assign oof_set   = fb_valid && !oof && !sync_regained && (err_cnt >= CW'(ERR_LIMIT));
  assign rlos_rise = rlos && !rlos_q;
  assign man_rise  = manual_rs && !man_q;
  assign auto_hit  = !auto_off && (oof_set || (!oof_only && rlos_rise));
  assign fire      = !busy && (man_rise || auto_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist         <= '0;
      oof          <= 1'b0;
      rlos_q       <= 1'b0;
      man_q        <= 1'b0;
      busy         <= 1'b0;
      resync_start <= 1'b0;
    end else begin
      rlos_q       <= rlos;
      man_q        <= manual_rs;
      resync_start <= fire;
      if (sync_regained) begin
        hist <= '0;
        oof  <= 1'b0;
      end else if (fb_valid && !oof) begin
        hist <= hist_nx;
        if (oof_set) oof <= 1'b1;
      end
      if (fire)               busy <= 1'b1;
      else if (sync_regained) busy <= 1'b0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !oof && !resync_start); // R1
  AST_OOF_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oof) |-> $past(fb_valid) && $past(fb_err)); // R5
  AST_REGAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_regained |=> !oof); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resync_start |=> !resync_start); // R7
  AST_AUTO_OFF_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    resync_start && $past(auto_off) |-> $past(manual_rs) && !$past(man_q)); // R8
  AST_MANUAL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    resync_start && $past(auto_off) |-> !$past(busy)); // R10
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    resync_start && !sync_regained |=> !resync_start [*1] ##1 (!resync_start || $past(sync_regained, 1) || $past(sync_regained, 2))); // R11

endmodule

// File: tb/oof_resync_ctrl_test.sv
module oof_resync_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_valid = 1'b0, fb_err = 1'b0, rlos = 1'b0, sync_regained = 1'b0;
  logic [1:0] oof_rule = 2'b00;
  logic auto_off = 1'b0, oof_only = 1'b0, manual_rs = 1'b0;
  logic oof, resync_start;
  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  oof_resync_ctrl uut (.*);

  always @(negedge clk) if (rst_n && resync_start) pulses++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bit_in(logic e);
    fb_valid = 1'b1; fb_err = e;
    @(negedge clk);
    fb_valid = 1'b0; fb_err = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regain();
    sync_regained = 1'b1;
    @(negedge clk);
    sync_regained = 1'b0;
    @(negedge clk);
  endtask

  task automatic pattern(string req, logic [1:0] rule, int gap, int exp_oof, int exp_p);
    int p0;
    regain();
    oof_rule = rule;
    p0 = pulses;
    bit_in(1'b1);
    for (int i = 0; i < gap - 1; i++) bit_in(1'b0);
    bit_in(1'b1);
    chk(req, oof, exp_oof);
    idle(2);
    chk(req, pulses - p0, exp_p);
  endtask

  task automatic t_reset();
    chk("R1 oof", oof, 0);
    chk("R1 pulse", resync_start, 0);
    bit_in(1'b1);
    chk("R1 empty history", oof, 0);
  endtask

  task automatic t_windows();
    auto_off = 1'b0;
    pattern("R2 in window", 2'b00, 3, 1, 1);
    pattern("R2 outside", 2'b00, 4, 0, 0);
    pattern("R3 in window", 2'b01, 4, 1, 1);
    pattern("R3 outside", 2'b01, 5, 0, 0);
    pattern("R4 rule10 in", 2'b10, 5, 1, 1);
    pattern("R4 rule11 in", 2'b11, 5, 1, 1);
    pattern("R4 outside", 2'b11, 6, 0, 0);
  endtask

  task automatic t_valid_gate();
    regain();
    oof_rule = 2'b00;
    fb_err = 1'b1; idle(5); fb_err = 1'b0;
    bit_in(1'b1);
    fb_err = 1'b1; idle(5); fb_err = 1'b0;
    chk("R5 err ignored", oof, 0);
    bit_in(1'b1);
    chk("R5 valid advance", oof, 1);
  endtask

  task automatic t_regain();
    chk("R6 precondition", oof, 1);
    regain();
    chk("R6 cleared", oof, 0);
    bit_in(1'b1);
    chk("R6 history empty", oof, 0);
  endtask

  task automatic t_pulse_timing();
    regain();
    auto_off = 1'b0; oof_rule = 2'b00;
    bit_in(1'b1);
    fb_valid = 1'b1; fb_err = 1'b1;
    @(negedge clk);
    fb_valid = 1'b0; fb_err = 1'b0;
    chk("R7 pulse with oof", resync_start, 1);
    chk("R7 oof same cycle", oof, 1);
    @(negedge clk);
    chk("R7 one cycle", resync_start, 0);
  endtask

  task automatic t_auto_off();
    int p0;
    regain();
    auto_off = 1'b1; oof_only = 1'b0;
    p0 = pulses;
    bit_in(1'b1); bit_in(1'b1);
    chk("R8 oof declared", oof, 1);
    rlos = 1'b1; idle(3); rlos = 1'b0; idle(2);
    chk("R8 no pulse", pulses - p0, 0);
    auto_off = 1'b0;
  endtask

  task automatic t_rlos();
    int p0;
    regain();
    oof_only = 1'b0;
    p0 = pulses;
    rlos = 1'b1; idle(4);
    chk("R9 rlos edge", pulses - p0, 1);
    regain();
    rlos = 1'b0; idle(1);
    oof_only = 1'b1;
    p0 = pulses;
    rlos = 1'b1; idle(4);
    chk("R9 oof only", pulses - p0, 0);
    rlos = 1'b0; oof_only = 1'b0; idle(1);
  endtask

  task automatic t_manual();
    int p0;
    regain();
    auto_off = 1'b1;
    p0 = pulses;
    manual_rs = 1'b1; idle(3);
    chk("R10 rise", pulses - p0, 1);
    regain();
    idle(4);
    chk("R10 held high", pulses - p0, 1);
    manual_rs = 1'b0; idle(1);
    manual_rs = 1'b1; idle(2);
    chk("R10 second rise", pulses - p0, 2);
    manual_rs = 1'b0; auto_off = 1'b0; idle(1);
  endtask

  task automatic t_busy();
    int p0;
    regain();
    p0 = pulses;
    manual_rs = 1'b1; idle(2); manual_rs = 1'b0; idle(1);
    chk("R11 first", pulses - p0, 1);
    manual_rs = 1'b1; idle(2); manual_rs = 1'b0;
    rlos = 1'b1; idle(2); rlos = 1'b0;
    bit_in(1'b1); bit_in(1'b1);
    idle(2);
    chk("R11 held off", pulses - p0, 1);
    regain();
    manual_rs = 1'b1; idle(2); manual_rs = 1'b0; idle(1);
    chk("R11 re-armed", pulses - p0, 2);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_windows();
    t_valid_gate();
    t_regain();
    t_pulse_timing();
    t_auto_off();
    t_rlos();
    t_manual();
    t_busy();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule